// File: doc/BRIEF.md
# Cartridge Boot Hold-and-Release Sequencer

This block answers the console's cartridge fetches while back-end storage is still loading the real program image. At power-up it serves a five-byte stub: both the reset vector and the interrupt/break vector point at the loop address $1000, and the byte at $1000 is a BRK opcode. The CPU therefore keeps re-entering $1000 and never reads undefined data while it waits.

Once the loader raises `load_done`, the block arms. It waits for the CPU to fetch $1000 again. In place of BRK it then serves the three bytes of an indirect jump through the reset vector, `JMP ($FFFC)`, at $1000, $1001 and $1002. After the third byte has been strobed, the block releases the bus for good. From then on every cartridge fetch, including the reset vector read that the jump performs, is answered from the loaded image.

A cartridge access is one with address bit 12 set. The data-drive enable follows that bit in every state.

Top module: `boot_hold_seq`

## Requirements
- R1: During and directly after reset, `released` is 0 and the stub is served. A fetch at $1000 returns $00.
- R2: `drive_en` is 1 exactly when `addr[12]` is 1, in every state. When `addr[12]` is 0, `data_out` is $00.
- R3: Before release, addresses $1FFC and $1FFE return $00 and addresses $1FFD and $1FFF return $10, so both vectors hold $1000.
- R4: Before the block arms, every other cartridge address returns $00 (BRK at $1000), whatever `addr_valid` does.
- R5: In the stub state, `load_done` seen at one clock edge arms the block, even if it falls again at once. After that edge, $1000 returns $6C. Without `load_done` the block stays in the stub state.
- R6: Once armed, a strobed fetch of $1000 starts the jump. $1001 then returns $FC, and after a strobed $1001, $1002 returns $FF.
- R7: `released` rises at the clock edge that samples a strobed $1002 while the jump is in its last byte. After that, every cartridge fetch returns `img_data`, including $1FFC to $1FFF.
- R8: During the jump, a strobed address that is neither the next jump byte nor $1000 returns the block to the armed state, and the stub byte is served for that address. A strobed $1000 restarts the jump from its first byte.
- R9: `released` is sticky until reset. `load_done` has no effect once released. Cycles with `addr_valid` low never advance the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 13 | Console address bus |
| addr_valid | input | 1 | Address is stable; the fetch counts at this edge |
| load_done | input | 1 | Back-end image has finished loading |
| img_data | input | 8 | Byte of the loaded image at `addr` |
| data_out | output | 8 | Value to place on the data bus |
| drive_en | output | 1 | Drive the data bus |
| released | output | 1 | Loaded image owns the bus |

## Verification
The hardest situation to reach is an interrupted jump. The sequence has to be armed and partly served, and then a fetch that does not continue it must arrive, before it is legal to check that the stub comes back and that a later $1000 restarts the jump. The stimulus arms the block with a single-cycle `load_done` pulse. It then breaks the jump once after its first byte with a vector fetch, and restarts it once from its second byte with a new $1000. Idle cycles with the strobe low are mixed in to show that they are not counted. Only after that does it complete the release and pulse `load_done` again against the released state.

// File: rtl/boot_hold_seq.sv
module boot_hold_seq #(
  parameter int AW = 13,
  parameter logic [AW-1:0] LOOP_ADDR = 13'h1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          addr_valid,
  input  logic          load_done,
  input  logic [7:0]    img_data,
  output logic [7:0]    data_out,
  output logic          drive_en,
  output logic          released
);
  localparam logic [15:0]   LOOP16  = 16'(LOOP_ADDR);
  localparam logic [7:0]    VEC_LO  = LOOP16[7:0];
  localparam logic [7:0]    VEC_HI  = LOOP16[15:8];
  localparam logic [7:0]    OP_BRK  = 8'h00;
  localparam logic [7:0]    OP_JMPI = 8'h6C;
  localparam logic [7:0]    PTR_LO  = 8'hFC;
  localparam logic [7:0]    PTR_HI  = 8'hFF;
  localparam logic [AW-1:0] JMP_B1  = LOOP_ADDR + AW'(1);
  localparam logic [AW-1:0] JMP_B2  = LOOP_ADDR + AW'(2);

  typedef enum logic [2:0] {S_STUB, S_ARM, S_J1, S_J2, S_REL} seq_t;
  seq_t st, st_nxt;

  wire cart    = addr[AW-1];
  wire at_loop = (addr == LOOP_ADDR);
  wire in_vec  = cart && (&addr[AW-2:2]);
  wire [7:0] stub_byte = in_vec ? (addr[0] ? VEC_HI : VEC_LO) : OP_BRK;

  always_comb begin
    st_nxt = st;
    unique case (st)
      S_STUB: if (load_done) st_nxt = S_ARM;
      S_ARM:  if (addr_valid && at_loop) st_nxt = S_J1;
      S_J1:   if (addr_valid) st_nxt = (addr == JMP_B1) ? S_J2 : (at_loop ? S_J1 : S_ARM);
      S_J2:   if (addr_valid) st_nxt = (addr == JMP_B2) ? S_REL : (at_loop ? S_J1 : S_ARM);
      S_REL:  st_nxt = S_REL;
      default: st_nxt = S_STUB;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= S_STUB;
    else        st <= st_nxt;

  always_comb begin
    if (!cart)                                   data_out = 8'h00;
    else if (st == S_REL)                        data_out = img_data;
    else if (st != S_STUB && at_loop)            data_out = OP_JMPI;
    else if (st == S_J1 && addr == JMP_B1)       data_out = PTR_LO;
    else if (st == S_J2 && addr == JMP_B2)       data_out = PTR_HI;
    else                                         data_out = stub_byte;
  end

  assign drive_en = cart;
  assign released = (st == S_REL);

  AST_RELEASE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    released |=> released); // R9
  AST_RELEASE_AFTER_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(released) |-> $past(addr_valid && addr == JMP_B2)); // R7
  AST_STUB_WAITS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STUB && !load_done) |=> (st == S_STUB && !released)); // R5
  AST_JMP_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == S_J1) |-> $past(addr_valid && at_loop)); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_valid && st != S_STUB) |=> $stable(st)); // R9
endmodule

// File: tb/boot_hold_seq_test.sv
`timescale 1ns/1ps
module boot_hold_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [12:0] addr = '0;
  logic addr_valid = 1'b0;
  logic load_done = 1'b0;
  logic [7:0] img_data = '0;
  wire  [7:0] data_out;
  wire  drive_en, released;

  boot_hold_seq uut (.clk(clk), .rst_n(rst_n), .addr(addr), .addr_valid(addr_valid),
    .load_done(load_done), .img_data(img_data), .data_out(data_out),
    .drive_en(drive_en), .released(released));

  always #2.5 clk = ~clk;

  logic [7:0] q_data[$];
  logic       q_en[$];
  logic       q_rel[$];
  string      q_tag[$];
  event       sample_ev;
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic step(input logic [12:0] a, input logic v, input logic ld,
                      input logic [7:0] img, input logic [7:0] ed,
                      input logic ee, input logic er, input string tag);
    @(negedge clk);
    addr = a; addr_valid = v; load_done = ld; img_data = img;
    q_data.push_back(ed); q_en.push_back(ee); q_rel.push_back(er); q_tag.push_back(tag);
    #1 -> sample_ev;
  endtask

  initial forever begin
    @(sample_ev);
    while (q_tag.size() > 0) begin
      logic [7:0] ed; logic ee, er; string t;
      ed = q_data.pop_front(); ee = q_en.pop_front();
      er = q_rel.pop_front(); t = q_tag.pop_front();
      checks++;
      if (data_out !== ed || drive_en !== ee || released !== er) begin
        fails++;
        $display("FAIL %s addr=%h: got data=%h en=%b rel=%b, expected data=%h en=%b rel=%b",
                 t, addr, data_out, drive_en, released, ed, ee, er);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; addr_valid = 1'b0; load_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    step(13'h1000, 0, 0, 8'hEE, 8'h00, 1, 0, "R1 reset stub");
    step(13'h1FFD, 0, 0, 8'hEE, 8'h10, 1, 0, "R3 reset vec hi");
    step(13'h0FFD, 1, 0, 8'hEE, 8'h00, 0, 0, "R2 non-cart no drive");
    step(13'h1FFC, 1, 0, 8'hEE, 8'h00, 1, 0, "R3 vec 1FFC");
    step(13'h1FFE, 1, 0, 8'hEE, 8'h00, 1, 0, "R3 vec 1FFE");
    step(13'h1FFF, 1, 0, 8'hEE, 8'h10, 1, 0, "R3 vec 1FFF");
    step(13'h1000, 1, 0, 8'hEE, 8'h00, 1, 0, "R4 BRK at loop");
    step(13'h1234, 1, 0, 8'hEE, 8'h00, 1, 0, "R4 other stub addr");
    step(13'h1000, 1, 0, 8'hEE, 8'h00, 1, 0, "R5 no arm without load");
    step(13'h1FFE, 1, 1, 8'hEE, 8'h00, 1, 0, "R5 load pulse");
    step(13'h1000, 0, 0, 8'hEE, 8'h6C, 1, 0, "R5 armed serves JMP");
    step(13'h1001, 0, 0, 8'hEE, 8'h00, 1, 0, "R9 idle keeps armed");
    step(13'h1000, 1, 0, 8'hEE, 8'h6C, 1, 0, "R6 jump start");
    step(13'h1FFC, 1, 0, 8'hEE, 8'h00, 1, 0, "R8 break serves stub");
    step(13'h1001, 1, 0, 8'hEE, 8'h00, 1, 0, "R8 back to armed");
    step(13'h1000, 1, 0, 8'hEE, 8'h6C, 1, 0, "R6 jump restart");
    step(13'h1001, 0, 0, 8'hEE, 8'hFC, 1, 0, "R9 idle in jump");
    step(13'h1001, 1, 0, 8'hEE, 8'hFC, 1, 0, "R6 second byte");
    step(13'h1000, 1, 0, 8'hEE, 8'h6C, 1, 0, "R8 restart from J2");
    step(13'h1001, 1, 0, 8'hEE, 8'hFC, 1, 0, "R6 second byte again");
    step(13'h1002, 0, 0, 8'hEE, 8'hFF, 1, 0, "R9 idle before tail");
    step(13'h1002, 1, 0, 8'hEE, 8'hFF, 1, 0, "R6 third byte");
    step(13'h1FFC, 1, 0, 8'h3C, 8'h3C, 1, 1, "R7 image vec lo");
    step(13'h1FFD, 1, 0, 8'hF0, 8'hF0, 1, 1, "R7 image vec hi");
    step(13'h1000, 1, 0, 8'h5A, 8'h5A, 1, 1, "R7 image at loop");
    step(13'h0800, 1, 0, 8'h5A, 8'h00, 0, 1, "R2 non-cart after release");
    step(13'h1002, 1, 1, 8'hA5, 8'hA5, 1, 1, "R9 load ignored");
    step(13'h1FFF, 0, 0, 8'h77, 8'h77, 1, 1, "R9 still released");
    do_reset();
    step(13'h1000, 1, 0, 8'h99, 8'h00, 1, 0, "R1 reset after release");
    step(13'h1FFF, 1, 0, 8'h99, 8'h10, 1, 0, "R1 stub vector back");
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule